// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Host Controller

This block drives a 16-bit successive-approximation analog-to-digital converter that has a three-wire serial port plus a conversion-start pin. A conversion starts on a one-cycle start request, or on a fixed-rate tick when automatic mode is enabled. The controller raises the start-of-conversion pin, waits out the conversion time, and then clocks sixteen serial clock pulses. During those pulses it reads the result MSB first and shifts a pending configuration word into the converter. The assembled sample is returned with a one-cycle valid strobe. A quiet window then holds off the next conversion.

Every timing limit is a parameter counted in system-clock cycles, rounded up from the converter's nanosecond limits. Elaboration stops with an error when the parameters break a limit. The limits checked are: the shortest rise-to-rise period, the acquisition window, the settle time from start-pin low to the first clock, the clock period against the output delay, and an automatic rate shorter than one frame.

The sequence runs through five states. IDLE goes to CNV_PULSE on a trigger. CNV_PULSE goes to CONV_WAIT when its pulse count ends. CONV_WAIT goes to SHIFT when the conversion time has been counted. SHIFT goes to QUIET after the last clock slot. QUIET returns to IDLE when the quiet count ends. Every pin and the result are registered.

Top module: `sar_host_ctrl`

## Requirements
- R1: While reset is asserted, `cnv_o`, `sck_o`, `din_o` and `valid_o` are 0 and `data_o` is all zeros.
- R2: A trigger sampled at a clock edge while the controller is idle makes `cnv_o` rise at the next edge and stay high for exactly CNV_HI_CYC cycles.
- R3: The first `sck_o` rising edge of a frame comes no earlier than CONV_CYC cycles after the `cnv_o` rising edge. `sck_o` is never high while `cnv_o` is high.
- R4: Each frame has exactly DATA_W clock pulses on `sck_o`. Each pulse has a low phase and a high phase of SCK_HALF_CYC cycles each. `sck_o` idles low.
- R5: `sdo_i` is captured at each falling edge of `sck_o` (the value present just before the edge), and the bits are assembled MSB first. Bit 15 is the value present before the first falling edge.
- R6: `valid_o` is high for exactly one cycle per frame, in the cycle right after the last falling edge of `sck_o`. `data_o` carries the assembled word in that cycle and holds it afterwards.
- R7: A word loaded with `cfg_load_i` is sent on `din_o` in the next frame, MSB (bit 15) first. Each bit changes at the clock edge where `sck_o` falls and stays stable while `sck_o` is high.
- R8: A frame started with no word pending keeps `din_o` at 0. A word loaded during a frame is sent in the following frame, not the current one.
- R9: Triggers that arrive while a frame is in progress are ignored. The next `cnv_o` rise comes at least QUIET_CYC+1 cycles after the last `sck_o` falling edge.
- R10: With `auto_en_i` high, a trigger is made every RATE_CYC cycles, the first one RATE_CYC cycles after the enable. Successive `cnv_o` rises are then exactly RATE_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-shot conversion request |
| auto_en_i | input | 1 | Enables fixed-rate triggering |
| cfg_word_i | input | DATA_W | Configuration word to send |
| cfg_load_i | input | 1 | Marks `cfg_word_i` pending for the next frame |
| sdo_i | input | 1 | Serial result from the converter |
| cnv_o | output | 1 | Conversion-start pin |
| sck_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial configuration data to the converter |
| data_o | output | DATA_W | Last assembled sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
Samples 16'h8001 and 16'h7FFE have a single bit that differs at each end, so a reversed or shifted capture order shows up at once. All-ones and all-zeros samples catch a stuck capture path. A config word followed by a frame with nothing pending separates a sent word from a held-low line, and a load made mid-frame shows whether the word is deferred to the next frame. Start pulses during a frame, a start held high across several frames, and automatic mode together test trigger rejection, the shortest back-to-back spacing and the fixed-rate period.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    typedef enum logic [2:0] {
        IDLE,
        CNV_PULSE,
        CONV_WAIT,
        SHIFT,
        QUIET
    } host_state_e;

endpackage

// File: rtl/sar_rate_timer.sv
module sar_rate_timer #(
    parameter int unsigned PERIOD_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int unsigned RW = $clog2(PERIOD_CYC + 1);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (cnt == RW'(PERIOD_CYC - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == RW'(PERIOD_CYC - 1));

endmodule

// File: rtl/sar_frame_shifter.sv
module sar_frame_shifter #(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned SCK_HALF_CYC = 2,
    parameter int unsigned PH_W         = 2,
    parameter int unsigned BIT_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              shifting,
    input  logic [PH_W-1:0]   phase,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic              cfg_send,
    input  logic              sdo,
    output logic              sck,
    output logic              din,
    output logic [DATA_W-1:0] data,
    output logic              valid
);

    logic              sck_nxt;
    logic              din_nxt;
    logic              fall;
    logic [DATA_W-1:0] shreg;
    logic [BIT_W-1:0]  cap_cnt;

    // high half of each bit slot drives the clock high
    assign sck_nxt = shifting && (phase >= PH_W'(SCK_HALF_CYC));
    assign din_nxt = shifting && cfg_send && cfg_word[BIT_W'(DATA_W - 1) - bit_idx];
    assign fall    = sck && !sck_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck     <= 1'b0;
            din     <= 1'b0;
            shreg   <= '0;
            cap_cnt <= '0;
            data    <= '0;
            valid   <= 1'b0;
        end else begin
            sck   <= sck_nxt;
            din   <= din_nxt;
            valid <= 1'b0;
            if (frame_start) begin
                cap_cnt <= '0;
            end else if (fall) begin
                shreg   <= {shreg[DATA_W-2:0], sdo};
                cap_cnt <= cap_cnt + 1'b1;
                if (cap_cnt == BIT_W'(DATA_W - 1)) begin
                    data  <= {shreg[DATA_W-2:0], sdo};
                    valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sar_host_ctrl.sv
module sar_host_ctrl
    import sar_host_pkg::*;
#(
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CNV_HI_CYC    = 2,
    parameter int unsigned CONV_CYC      = 160,
    parameter int unsigned CLSCK_CYC     = 1,
    parameter int unsigned SCK_HALF_CYC  = 2,
    parameter int unsigned DSDO_CYC      = 3,
    parameter int unsigned QUIET_CYC     = 4,
    parameter int unsigned ACQ_CYC       = 40,
    parameter int unsigned CYCLE_MIN_CYC = 200,
    parameter int unsigned RATE_CYC      = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              auto_en_i,
    input  logic [DATA_W-1:0] cfg_word_i,
    input  logic              cfg_load_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sck_o,
    output logic              din_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    localparam int unsigned WAIT_CYC  = CONV_CYC - CNV_HI_CYC;
    localparam int unsigned SLOT_CYC  = 2 * SCK_HALF_CYC;
    localparam int unsigned SHIFT_CYC = SLOT_CYC * DATA_W;
    localparam int unsigned FRAME_CYC = CNV_HI_CYC + WAIT_CYC + SHIFT_CYC + QUIET_CYC + 1;
    localparam int unsigned CNT_W     = $clog2(CNV_HI_CYC + WAIT_CYC + QUIET_CYC + 1);
    localparam int unsigned PH_W      = $clog2(SLOT_CYC);
    localparam int unsigned BIT_W     = $clog2(DATA_W);

    // parameter sanity, reported during elaboration
    if (CONV_CYC <= CNV_HI_CYC || CNV_HI_CYC == 0 || QUIET_CYC == 0) begin : g_bad_pulse
        $error("conversion time must exceed a nonzero start pulse; quiet count must be nonzero");
    end
    if (WAIT_CYC < CLSCK_CYC) begin : g_bad_settle
        $error("start-low to first clock settle time too short");
    end
    if (SLOT_CYC < DSDO_CYC + 1) begin : g_bad_sck
        $error("serial clock period shorter than converter output delay");
    end
    if (FRAME_CYC < CYCLE_MIN_CYC) begin : g_bad_cycle
        $error("frame shorter than minimum conversion cycle");
    end
    if (FRAME_CYC - CONV_CYC < ACQ_CYC) begin : g_bad_acq
        $error("acquisition window too short");
    end
    if (RATE_CYC < FRAME_CYC) begin : g_bad_rate
        $error("automatic rate shorter than one frame");
    end

    host_state_e       state;
    host_state_e       state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [PH_W-1:0]   phase;
    logic [BIT_W-1:0]  bit_idx;
    logic              rate_tick;
    logic              trigger;
    logic              frame_start;
    logic              last_slot;
    logic              pend;
    logic [DATA_W-1:0] pend_word;
    logic              frame_send;
    logic [DATA_W-1:0] frame_word;

    sar_rate_timer #(
        .PERIOD_CYC (RATE_CYC)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (auto_en_i),
        .tick  (rate_tick)
    );

    assign trigger     = start_i || rate_tick;
    assign frame_start = (state == IDLE) && trigger;
    assign last_slot   = (phase == PH_W'(SLOT_CYC - 1)) && (bit_idx == BIT_W'(DATA_W - 1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            IDLE:      if (trigger) state_nxt = CNV_PULSE;
            CNV_PULSE: if (cnt == CNT_W'(CNV_HI_CYC - 1)) state_nxt = CONV_WAIT;
            CONV_WAIT: if (cnt == CNT_W'(WAIT_CYC - 1)) state_nxt = SHIFT;
            SHIFT:     if (last_slot) state_nxt = QUIET;
            QUIET:     if (cnt == CNT_W'(QUIET_CYC - 1)) state_nxt = IDLE;
            default:   state_nxt = IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            phase   <= '0;
            bit_idx <= '0;
        end else if (state != state_nxt || state == IDLE) begin
            cnt     <= '0;
            phase   <= '0;
            bit_idx <= '0;
        end else if (state == SHIFT) begin
            if (phase == PH_W'(SLOT_CYC - 1)) begin
                phase   <= '0;
                bit_idx <= bit_idx + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // pending config is latched into the frame at its start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            pend_word  <= '0;
            frame_send <= 1'b0;
            frame_word <= '0;
        end else if (frame_start) begin
            frame_send <= pend;
            frame_word <= pend_word;
            pend       <= cfg_load_i;
            if (cfg_load_i) pend_word <= cfg_word_i;
        end else if (cfg_load_i) begin
            pend      <= 1'b1;
            pend_word <= cfg_word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_o <= 1'b0;
        end else begin
            cnv_o <= (state == CNV_PULSE);
        end
    end

    sar_frame_shifter #(
        .DATA_W       (DATA_W),
        .SCK_HALF_CYC (SCK_HALF_CYC),
        .PH_W         (PH_W),
        .BIT_W        (BIT_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .shifting    (state == SHIFT),
        .phase       (phase),
        .bit_idx     (bit_idx),
        .cfg_word    (frame_word),
        .cfg_send    (frame_send),
        .sdo         (sdo_i),
        .sck         (sck_o),
        .din         (din_o),
        .data        (data_o),
        .valid       (valid_o)
    );

endmodule

// File: rtl/sar_host_ctrl_chk.sv
module sar_host_ctrl_chk #(
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CNV_HI_CYC    = 2,
    parameter int unsigned CONV_CYC      = 160,
    parameter int unsigned QUIET_CYC     = 4,
    parameter int unsigned CYCLE_MIN_CYC = 200
) (
    input logic clk,
    input logic rst_n,
    input logic cnv_o,
    input logic sck_o,
    input logic din_o,
    input logic valid_o
);

    logic        cnv_q;
    logic        sck_q;
    logic [15:0] hi_run;
    logic [15:0] since_cnv;
    logic [15:0] since_fall;
    logic [15:0] rises;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_q      <= 1'b0;
            sck_q      <= 1'b0;
            hi_run     <= '0;
            since_cnv  <= 16'hFFFF;
            since_fall <= 16'hFFFF;
            rises      <= '0;
        end else begin
            cnv_q  <= cnv_o;
            sck_q  <= sck_o;
            hi_run <= cnv_o ? hi_run + 1'b1 : 16'd0;
            if (cnv_o && !cnv_q) since_cnv <= 16'd1;
            else if (since_cnv != 16'hFFFF) since_cnv <= since_cnv + 1'b1;
            if (!sck_o && sck_q) since_fall <= 16'd1;
            else if (since_fall != 16'hFFFF) since_fall <= since_fall + 1'b1;
            if (cnv_o && !cnv_q) rises <= '0;
            else if (sck_o && !sck_q) rises <= rises + 1'b1;
        end
    end

    AST_CNV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(cnv_o) |-> hi_run == 16'(CNV_HI_CYC)); // R2
    AST_CONV_DONE_BEFORE_SCK: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck_o) |-> since_cnv >= 16'(CONV_CYC)); // R3
    AST_SCK_LOW_WITH_CNV: assert property (@(posedge clk) disable iff (!rst_n) cnv_o |-> !sck_o); // R3
    AST_SIXTEEN_PULSES: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> rises == 16'(DATA_W)); // R4
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o); // R6
    AST_DIN_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sck_o && $past(sck_o)) |-> $stable(din_o)); // R7
    AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(cnv_o) |-> since_fall > 16'(QUIET_CYC)); // R9
    AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) $rose(cnv_o) |-> since_cnv >= 16'(CYCLE_MIN_CYC)); // R9

endmodule

bind sar_host_ctrl sar_host_ctrl_chk #(
    .DATA_W        (DATA_W),
    .CNV_HI_CYC    (CNV_HI_CYC),
    .CONV_CYC      (CONV_CYC),
    .QUIET_CYC     (QUIET_CYC),
    .CYCLE_MIN_CYC (CYCLE_MIN_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnv_o   (cnv_o),
    .sck_o   (sck_o),
    .din_o   (din_o),
    .valid_o (valid_o)
);

// File: tb/sar_host_ctrl_tb.sv
`timescale 1ns/1ps
module sar_host_ctrl_tb;

    localparam int DW    = 16;
    localparam int P     = 2;
    localparam int CONV  = 160;
    localparam int H     = 2;
    localparam int Q     = 4;
    localparam int RATE  = 250;
    localparam int W     = CONV - P;
    localparam int S     = 2 * H * DW;
    localparam int SH0   = P + W;
    localparam int ENDK  = P + W + S + Q;
    localparam int FRAME = ENDK + 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic          auto_en_i;
    logic [DW-1:0] cfg_word_i;
    logic          cfg_load_i;
    logic          sdo_i = 1'b0;
    logic          cnv_o;
    logic          sck_o;
    logic          din_o;
    logic [DW-1:0] data_o;
    logic          valid_o;

    always #5 clk = ~clk;

    sar_host_ctrl #(
        .DATA_W (DW), .CNV_HI_CYC (P), .CONV_CYC (CONV), .CLSCK_CYC (1),
        .SCK_HALF_CYC (H), .DSDO_CYC (3), .QUIET_CYC (Q), .ACQ_CYC (40),
        .CYCLE_MIN_CYC (200), .RATE_CYC (RATE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .auto_en_i (auto_en_i),
        .cfg_word_i (cfg_word_i), .cfg_load_i (cfg_load_i), .sdo_i (sdo_i),
        .cnv_o (cnv_o), .sck_o (sck_o), .din_o (din_o), .data_o (data_o), .valid_o (valid_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // converter model
    int            adc_frames = 0;
    int            adc_pos = 0;
    logic [DW-1:0] adc_word = '0;

    function automatic logic [DW-1:0] sample_for(input int i);
        case (i)
            0: return 16'h8001;
            1: return 16'h7FFE;
            2: return 16'hFFFF;
            3: return 16'h0000;
            default: return DW'(i * 16'h3B1F) ^ 16'hA5A5;
        endcase
    endfunction

    always @(negedge cnv_o) if (rst_n) begin
        adc_word = sample_for(adc_frames);
        adc_frames++;
        adc_pos = DW - 1;
        sdo_i = adc_word[DW-1];
    end

    always @(negedge sck_o) if (rst_n) begin
        #1;
        if (adc_pos > 0) begin
            adc_pos--;
            sdo_i = adc_word[adc_pos];
        end
    end

    // behavioural reference
    int            k = 0;
    bit            act = 0;
    bit            pend = 0;
    logic [DW-1:0] pend_w = '0;
    bit            f_send = 0;
    logic [DW-1:0] f_w = '0;
    int            rcnt = 0;
    bit            tick;
    int            cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            k = 0; act = 0; pend = 0; pend_w = '0; f_send = 0; f_w = '0; rcnt = 0;
        end else begin
            tick = auto_en_i && (rcnt == RATE - 1);
            if (!auto_en_i || rcnt == RATE - 1) rcnt = 0;
            else rcnt++;
            if ((!act || k >= ENDK) && (start_i || tick)) begin
                act = 1; k = 0;
                f_send = pend; f_w = pend_w;
                pend = cfg_load_i;
                if (cfg_load_i) pend_w = cfg_word_i;
            end else begin
                if (act) k++;
                if (cfg_load_i) begin pend = 1; pend_w = cfg_word_i; end
            end
        end
    end

    // per-cycle comparison
    bit e_cnv, e_sck, e_din, e_valid;
    bit cnv_prev = 0, sck_prev = 0;
    int last_rise = -1, last_fall = -1, sck_in_frame = 0;
    int exp_frames = 0, seen_frames = 0;
    bit auto_chk = 0, prev_auto = 0;

    always @(negedge clk) if (rst_n && !done) begin
        int t;
        e_cnv = act && k >= 1 && k <= P;
        e_sck = 0;
        e_din = 0;
        if (act && k >= SH0 + 1 && k <= SH0 + S) begin
            t = k - SH0 - 1;
            e_sck = (t % (2 * H)) >= H;
            e_din = f_send && f_w[DW - 1 - t / (2 * H)];
        end
        e_valid = act && k == SH0 + S + 1;
        chk(cnv_o == e_cnv, "R2 cnv", int'(cnv_o), int'(e_cnv));
        chk(sck_o == e_sck, "R4 sck", int'(sck_o), int'(e_sck));
        if (f_send) chk(din_o == e_din, "R7 din", int'(din_o), int'(e_din));
        else        chk(din_o == e_din, "R8 din", int'(din_o), int'(e_din));
        chk(valid_o == e_valid, "R6 valid", int'(valid_o), int'(e_valid));
        if (e_valid) begin
            exp_frames++;
            chk(data_o == adc_word, "R5 data", int'(data_o), int'(adc_word));
        end
        if (valid_o) seen_frames++;
        if (cnv_o && !cnv_prev) begin
            if (last_fall >= 0)
                chk(cyc - last_fall >= Q + 1, "R9 quiet", cyc - last_fall, Q + 1);
            if (auto_chk && prev_auto)
                chk(cyc - last_rise == RATE, "R10 rate", cyc - last_rise, RATE);
            prev_auto = auto_chk;
            last_rise = cyc;
            sck_in_frame = 0;
        end
        if (sck_o && !sck_prev) begin
            if (sck_in_frame == 0)
                chk(cyc - last_rise >= CONV, "R3 conv wait", cyc - last_rise, CONV);
            sck_in_frame++;
        end
        if (!sck_o && sck_prev) last_fall = cyc;
        cnv_prev = cnv_o;
        sck_prev = sck_o;
    end

    task automatic load_cfg(input logic [DW-1:0] v);
        cfg_word_i = v;
        cfg_load_i = 1'b1;
        @(negedge clk);
        cfg_load_i = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; auto_en_i = 1'b0;
        cfg_word_i = '0; cfg_load_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(cnv_o == 1'b0, "R1 cnv", int'(cnv_o), 0);
        chk(sck_o == 1'b0, "R1 sck", int'(sck_o), 0);
        chk(din_o == 1'b0, "R1 din", int'(din_o), 0);
        chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
        chk(data_o == '0, "R1 data", int'(data_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // config word then frame with it (R7)
        load_cfg(16'hA5C3);
        pulse_start();
        repeat (FRAME + 5) @(negedge clk);
        // nothing pending: din held low (R8)
        pulse_start();
        repeat (FRAME + 5) @(negedge clk);
        // starts during a frame are ignored (R9), mid-frame load deferred (R8)
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();
        load_cfg(16'h3C96);
        repeat (100) @(negedge clk);
        pulse_start();
        repeat (FRAME) @(negedge clk);
        pulse_start();
        repeat (FRAME + 5) @(negedge clk);
        // start held high: back-to-back frames at minimum spacing
        start_i = 1'b1;
        repeat (2 * FRAME + 10) @(negedge clk);
        start_i = 1'b0;
        repeat (FRAME + 5) @(negedge clk);
        // fixed-rate mode (R10)
        load_cfg(16'h0F0F);
        auto_en_i = 1'b1;
        auto_chk = 1;
        repeat (4 * RATE + 20) @(negedge clk);
        auto_en_i = 1'b0;
        repeat (FRAME + 5) @(negedge clk);
        auto_chk = 0;
        chk(seen_frames == exp_frames, "R9 frame count", seen_frames, exp_frames);
        chk(exp_frames >= 10, "R10 frames run", exp_frames, 10);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule